// File: doc/BRIEF.md
# Busbar Differential Trip Sequencer

This block is the decision core of a centralised protection relay for one DC busbar. It works at the sample rate of the measurement stream (typically 96 kHz, about 10.42 µs per sample). Each sample carries several inputs:

- one signed converter current and one signed current per connected line;
- a precomputed fault-detection magnitude for every current channel;
- a precomputed wavelet magnitude for every line voltage.

The block adds all busbar currents into a differential sum and then runs a staged decision. The first stage waits for any detection magnitude to cross its threshold. The second stage checks the differential magnitude on that same sample. If the differential magnitude is above its threshold, the fault is on the busbar: every breaker trips and the sequence stops. Otherwise the fault is taken to be on a line, and a selection window opens. During the window, each line whose wavelet magnitude crosses the wavelet threshold has its own breaker tripped.

Trip bits latch and clear only on reset or on the re-arm input. The three thresholds and the window length are inputs, so that a surrounding register bank can program them. Suggested values in units of 0.1 A are 435 for detection and 750 for differential, with 1000 for the wavelet magnitude. A decision is reached within a few samples of inception, far below 1 ms.

Top module: `busbar_trip_seq`

## Requirements
- R1: After rst_ni is low, or after any cycle in which rearm_i is high, trip_o is all zero and status_o is 0 (idle). rearm_i takes priority over a sample in the same cycle.
- R2: While idle, a valid sample in which no fds_i channel is strictly greater than th_fds_i changes neither trip_o nor status_o. A magnitude equal to the threshold does not start a sequence.
- R3: The differential value is the signed sum of the converter current and all line currents (two's complement inputs). It is formed without overflow even at full scale on every channel, and its absolute value is compared strictly against th_dif_i.
- R4: On the inception sample, an absolute differential strictly above th_dif_i sets every trip bit on the next cycle. These are line bits 0..N-1 and converter bit N. status_o becomes 2 (busbar trip). Further samples are then ignored until re-arm.
- R5: On the inception sample, an absolute differential not above th_dif_i sets status_o to 1 (line selection) and trips nothing. Wavelet inputs of that inception sample are not used.
- R6: During selection, on each valid sample, each line whose wav_i magnitude is strictly greater than th_wav_i gets its trip bit set. Equality does not trip, and the converter bit N is never set in selection.
- R7: The selection window is max(win_len_i, 1) valid samples after the inception sample, with win_len_i captured at inception. When the window ends with a line tripped, status_o becomes 3 (line trip) and the block holds until re-arm. When it ends with nothing tripped, status_o becomes 4 (no trip) and the block is idle again, so a later inception starts a new sequence.
- R8: A set trip bit stays set until reset or re-arm. After a busbar trip or a line trip, no input changes trip_o or status_o.
- R9: Cycles with sample_valid_i low change no output and do not advance the selection window.
- R10: A wavelet crossing on the last sample of the window is honoured, so the block ends with status 3 rather than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rearm_i | input | 1 | Synchronous re-arm: clears trips and status |
| sample_valid_i | input | 1 | Marks a cycle that carries a new sample |
| conv_cur_i | input | CUR_W | Signed converter current |
| line_cur_i | input | N_LINES*CUR_W | Signed line currents, line k at bits k*CUR_W |
| fds_i | input | (N_LINES+1)*MAG_W | Fault-detection magnitudes, channel N_LINES is the converter |
| wav_i | input | N_LINES*MAG_W | Wavelet magnitudes per line |
| th_fds_i | input | MAG_W | Detection threshold |
| th_dif_i | input | CUR_W | Differential threshold (unsigned) |
| th_wav_i | input | MAG_W | Wavelet threshold |
| win_len_i | input | WIN_W | Selection window length in samples (0 acts as 1) |
| trip_o | output | N_LINES+1 | Latched trip per breaker, bit N_LINES is the converter |
| status_o | output | 3 | 0 idle, 1 selecting, 2 busbar trip, 3 line trip, 4 no trip |

## Verification
Two pairs of decisions can fall on one sample.

The first pair is a busbar-level differential and a large wavelet magnitude on the inception sample. The bench provokes it by driving both together. It judges that all bits including the converter trip with status 2, and that no line-only pattern appears.

The second pair is the end of the selection window and a fresh wavelet crossing. The bench puts the crossing exactly on the last window sample and expects status 3 with that line's bit set, not the no-trip return. Random stretches with re-arms mixed in compare every cycle against a bench-side model of the sequence.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [2:0] {
    STAT_IDLE   = 3'd0,
    STAT_SELECT = 3'd1,
    STAT_BUS    = 3'd2,
    STAT_LINE   = 3'd3,
    STAT_NONE   = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SELECT = 2'd1,
    PH_DONE   = 2'd2
  } phase_e;

endpackage

// File: rtl/bbs_diff_sum.sv
module bbs_diff_sum #(
  parameter int N_LINES = 4,
  parameter int CUR_W   = 16,
  parameter int SUM_W   = CUR_W + $clog2(N_LINES + 1) + 1
) (
  input  logic [CUR_W-1:0]         conv_i,
  input  logic [N_LINES*CUR_W-1:0] lines_i,
  output logic [SUM_W-1:0]         mag_o
);

  localparam int EXT_W = SUM_W - CUR_W;

  logic signed [SUM_W-1:0] ext_line [N_LINES];
  logic signed [SUM_W-1:0] ext_conv;
  logic signed [SUM_W-1:0] acc;

  assign ext_conv = {{EXT_W{conv_i[CUR_W-1]}}, conv_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_ext
    assign ext_line[g] = {{EXT_W{lines_i[g*CUR_W+CUR_W-1]}}, lines_i[g*CUR_W +: CUR_W]};
  end

  always_comb begin
    acc = ext_conv;
    for (int k = 0; k < N_LINES; k++) begin
      acc = acc + ext_line[k];
    end
  end

  // headroom guarantees -acc is representable
  assign mag_o = acc[SUM_W-1] ? SUM_W'(-acc) : SUM_W'(acc);

endmodule

// File: rtl/bbs_over_cmp.sv
module bbs_over_cmp #(
  parameter int CH = 4,
  parameter int W  = 16
) (
  input  logic [CH*W-1:0] val_i,
  input  logic [W-1:0]    th_i,
  output logic [CH-1:0]   over_o
);

  for (genvar c = 0; c < CH; c++) begin : g_cmp
    assign over_o[c] = val_i[c*W +: W] > th_i;
  end

endmodule

// File: rtl/bbs_window_ctr.sv
module bbs_window_ctr #(
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIN_W-1:0] len_i,
  input  logic             step_i,
  input  logic             active_i,
  output logic             last_o
);

  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? WIN_W'(1) : len_i;
    end else if (step_i && cnt_q > WIN_W'(1)) begin
      cnt_q <= cnt_q - WIN_W'(1);
    end
  end

  assign last_o = (cnt_q == WIN_W'(1));

  // R7: an open window always has samples left
  p_cnt_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q != '0));

endmodule

// File: rtl/busbar_trip_seq.sv
module busbar_trip_seq
  import bbs_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int CUR_W   = 16,
  parameter int MAG_W   = 16,
  parameter int WIN_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rearm_i,
  input  logic                         sample_valid_i,
  input  logic [CUR_W-1:0]             conv_cur_i,
  input  logic [N_LINES*CUR_W-1:0]     line_cur_i,
  input  logic [(N_LINES+1)*MAG_W-1:0] fds_i,
  input  logic [N_LINES*MAG_W-1:0]     wav_i,
  input  logic [MAG_W-1:0]             th_fds_i,
  input  logic [CUR_W-1:0]             th_dif_i,
  input  logic [MAG_W-1:0]             th_wav_i,
  input  logic [WIN_W-1:0]             win_len_i,
  output logic [N_LINES:0]             trip_o,
  output logic [2:0]                   status_o
);

  localparam int SUM_W = CUR_W + $clog2(N_LINES + 1) + 1;
  localparam logic [SUM_W:0] MAX_MAG = (SUM_W+1)'(N_LINES + 1) << (CUR_W - 1);

  logic [SUM_W-1:0] dif_mag;
  logic [N_LINES:0] fds_over;
  logic [N_LINES-1:0] wav_over;
  logic dif_over, incept, win_last;
  logic enter_sel, step_sel;

  phase_e            phase_q;
  status_e           status_q;
  logic [N_LINES:0]  trip_q;

  bbs_diff_sum #(.N_LINES(N_LINES), .CUR_W(CUR_W), .SUM_W(SUM_W)) u_diff (
    .conv_i (conv_cur_i),
    .lines_i(line_cur_i),
    .mag_o  (dif_mag)
  );

  bbs_over_cmp #(.CH(N_LINES + 1), .W(MAG_W)) u_fds_cmp (
    .val_i (fds_i),
    .th_i  (th_fds_i),
    .over_o(fds_over)
  );

  bbs_over_cmp #(.CH(N_LINES), .W(MAG_W)) u_wav_cmp (
    .val_i (wav_i),
    .th_i  (th_wav_i),
    .over_o(wav_over)
  );

  assign dif_over  = dif_mag > SUM_W'(th_dif_i);
  assign incept    = sample_valid_i && (|fds_over);
  assign enter_sel = !rearm_i && phase_q == PH_IDLE && incept && !dif_over;
  assign step_sel  = !rearm_i && phase_q == PH_SELECT && sample_valid_i;

  bbs_window_ctr #(.WIN_W(WIN_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rearm_i),
    .load_i  (enter_sel),
    .len_i   (win_len_i),
    .step_i  (step_sel),
    .active_i(phase_q == PH_SELECT),
    .last_o  (win_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      status_q <= STAT_IDLE;
      trip_q   <= '0;
    end else if (rearm_i) begin
      phase_q  <= PH_IDLE;
      status_q <= STAT_IDLE;
      trip_q   <= '0;
    end else if (sample_valid_i) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (incept) begin
            if (dif_over) begin
              trip_q   <= '1;
              phase_q  <= PH_DONE;
              status_q <= STAT_BUS;
            end else begin
              phase_q  <= PH_SELECT;
              status_q <= STAT_SELECT;
            end
          end
        end
        PH_SELECT: begin
          trip_q[N_LINES-1:0] <= trip_q[N_LINES-1:0] | wav_over;
          if (win_last) begin
            if ((|trip_q[N_LINES-1:0]) || (|wav_over)) begin
              phase_q  <= PH_DONE;
              status_q <= STAT_LINE;
            end else begin
              phase_q  <= PH_IDLE;
              status_q <= STAT_NONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign trip_o   = trip_q;
  assign status_o = status_q;

  // R3
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, dif_mag} <= MAX_MAG));

  // R2
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !rearm_i && !incept) |=> ($stable(trip_q) && $stable(status_q)));

  // R4
  p_bus_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !rearm_i && incept && dif_over) |=> ((&trip_o) && status_o == 3'd2));

  // R6
  p_conv_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SELECT && !rearm_i) |=> !trip_o[N_LINES]);

  // R8
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rearm_i |=> ((trip_o & $past(trip_o)) == $past(trip_o)));

  // R8
  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && !rearm_i) |=> ($stable(trip_o) && $stable(status_o)));

  // R1
  p_rearm_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (trip_o == '0 && status_o == 3'd0));

endmodule

// File: tb/busbar_trip_seq_bench.sv
`timescale 1ns/1ps
module busbar_trip_seq_bench;

  localparam int N  = 4;
  localparam int CW = 16;
  localparam int MW = 16;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rearm, valid;
  logic [CW-1:0] conv;
  logic [N*CW-1:0] lcur;
  logic [(N+1)*MW-1:0] fds;
  logic [N*MW-1:0] wav;
  logic [MW-1:0] th_fds, th_wav;
  logic [CW-1:0] th_dif;
  logic [WW-1:0] win;
  logic [N:0] trip;
  logic [2:0] status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  int m_ph = 0;
  int m_cnt = 0;
  logic [N:0] m_trip = '0;
  logic [2:0] m_stat = 3'd0;

  always #5 clk = ~clk;

  busbar_trip_seq #(.N_LINES(N), .CUR_W(CW), .MAG_W(MW), .WIN_W(WW)) u_busbar_trip_seq (
    .clk_i(clk), .rst_ni(rst_n), .rearm_i(rearm), .sample_valid_i(valid),
    .conv_cur_i(conv), .line_cur_i(lcur), .fds_i(fds), .wav_i(wav),
    .th_fds_i(th_fds), .th_dif_i(th_dif), .th_wav_i(th_wav), .win_len_i(win),
    .trip_o(trip), .status_o(status)
  );

  function automatic int diff_abs();
    int s;
    s = int'($signed(conv));
    for (int k = 0; k < N; k++) s += int'($signed(lcur[k*CW +: CW]));
    return (s < 0) ? -s : s;
  endfunction

  function automatic bit any_fds();
    bit r = 0;
    for (int k = 0; k <= N; k++) if (fds[k*MW +: MW] > th_fds) r = 1;
    return r;
  endfunction

  task automatic model();
    if (rearm) begin
      m_ph = 0; m_trip = '0; m_stat = 3'd0; m_cnt = 0;
    end else if (valid) begin
      case (m_ph)
        0: if (any_fds()) begin
          if (diff_abs() > int'(th_dif)) begin
            m_trip = '1; m_ph = 2; m_stat = 3'd2;
          end else begin
            m_ph = 1; m_stat = 3'd1; m_cnt = (win == 0) ? 1 : int'(win);
          end
        end
        1: begin
          for (int k = 0; k < N; k++) if (wav[k*MW +: MW] > th_wav) m_trip[k] = 1'b1;
          if (m_cnt == 1) begin
            if (m_trip != '0) begin m_ph = 2; m_stat = 3'd3; end
            else begin m_ph = 0; m_stat = 3'd4; end
          end else m_cnt--;
        end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag);
    total++;
    if (trip !== m_trip || status !== m_stat) begin
      bad++;
      $display("FAIL %s trip=%h exp=%h status=%0d exp=%0d", tag, trip, m_trip, status, m_stat);
    end
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag);
  endtask

  task automatic quiet();
    rearm = 0; valid = 0; conv = '0; lcur = '0; fds = '0; wav = '0;
  endtask

  task automatic do_rearm(input string tag);
    quiet(); rearm = 1; step(tag); rearm = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    th_fds = 16'd435; th_dif = 16'd750; th_wav = 16'd1000; win = 8'd3;
    @(negedge clk); @(negedge clk);
    chk("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset release");

    // R2: detection equal to threshold, huge differential
    valid = 1; fds[0 +: MW] = 16'd435; fds[N*MW +: MW] = 16'd435; conv = 16'd9000;
    step("R2 equal detection ignored");

    // R9: invalid sample with crossing detection
    valid = 0; fds[0 +: MW] = 16'd5000;
    step("R9 invalid sample ignored");

    // R5: differential equal to threshold -> selection; wavelet of inception unused
    quiet(); valid = 1; fds[2*MW +: MW] = 16'd436; conv = 16'd750;
    wav[3*MW +: MW] = 16'd2000;
    step("R5 enter selection");
    quiet(); valid = 1; wav[1*MW +: MW] = 16'd1000;
    step("R6 equal wavelet no trip");
    quiet(); valid = 0; wav[3*MW +: MW] = 16'd3000;
    step("R9 invalid in window");
    quiet(); valid = 1; wav[2*MW +: MW] = 16'd1001;
    step("R6 line2 trip");
    quiet(); valid = 1; wav[0 +: MW] = 16'd1001;
    step("R10 crossing on last window sample");
    quiet(); valid = 1; wav = '1; fds = '1; conv = 16'd20000;
    step("R8 hold after line trip");
    do_rearm("R1 rearm clears line trip");

    // R4 + R3: negative differential, with wavelet crossing in same sample
    quiet(); valid = 1; fds[N*MW +: MW] = 16'd800; conv = -16'sd751; wav = '1;
    step("R4 busbar trip negative diff");
    quiet(); valid = 1; fds = '1;
    step("R8 hold after busbar trip");
    // R1: rearm beats a simultaneous sample
    quiet(); rearm = 1; valid = 1; fds = '1; conv = 16'd30000;
    step("R1 rearm priority"); rearm = 0;

    // R3: full-scale positive currents on every channel
    th_dif = 16'hFFFF;
    quiet(); valid = 1; fds[0 +: MW] = 16'd999; conv = 16'h7FFF;
    for (int k = 0; k < N; k++) lcur[k*CW +: CW] = 16'h7FFF;
    step("R3 full-scale sum no overflow");
    do_rearm("R1 rearm after full scale");
    th_dif = 16'd750;

    // R7: expiry with no trip, then re-inception works
    win = 8'd2;
    quiet(); valid = 1; fds[1*MW +: MW] = 16'd500;
    step("R7 enter window");
    quiet(); valid = 1;
    step("R7 window sample 1");
    quiet(); valid = 1; wav[1*MW +: MW] = 16'd999;
    step("R7 window expiry no trip");
    quiet(); valid = 1; fds[1*MW +: MW] = 16'd500; conv = 16'd2000;
    step("R7 re-inception after no trip");
    do_rearm("R1 rearm");

    // R7: zero length behaves as one
    win = 8'd0;
    quiet(); valid = 1; fds[0 +: MW] = 16'd500;
    step("R7 zero window enter");
    quiet(); valid = 1; wav[3*MW +: MW] = 16'd1500;
    step("R7 zero window single sample");
    do_rearm("R1 rearm");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      rearm = ($urandom_range(39) == 0);
      valid = ($urandom_range(3) != 0);
      conv = CW'($urandom_range(1999) - 1000);
      for (int k = 0; k < N; k++) begin
        lcur[k*CW +: CW] = CW'($urandom_range(799) - 400);
        wav[k*MW +: MW]  = MW'($urandom_range(1150));
      end
      for (int k = 0; k <= N; k++) fds[k*MW +: MW] = MW'($urandom_range(470));
      if ($urandom_range(7) == 0) win = WW'($urandom_range(6));
      step("R8 random sequence");
    end

    summary();
  end

endmodule